// File: doc/BRIEF.md
# Auxiliary RAM Access Router

This block sits on the external-data access port of an 8-bit controller core. Each data transfer the core issues arrives with an address, a write value and a read or write strobe. The block sends the transfer either to a small on-chip scratch RAM or out through the external memory bus interface. The route depends on three things: how the core formed the address, a software enable bit in the chip control byte, and, for 16-bit pointer transfers only, whether the upper address byte is zero.

When the on-chip RAM serves a transfer, the block keeps the external bus quiet. No address latch pulse and no read or write strobe are issued. When code is being fetched from internal program memory, the external address and data outputs also hold their previous values. When code comes from external memory, those outputs may follow the transfer address, but the strobes are still blocked, so external memory is never written by mistake.

Read data returns to the core in a fixed slot on both routes, so core timing is the same whichever path serves the read. A strobe in cycle t produces a one-cycle `core_rvalid` pulse in cycle t+2.

Top module: `auxram_router`

## Requirements
- R1: The on-chip RAM stores 256 bytes, indexed by address bits [7:0]; a read served internally returns the last value written internally to that index.
- R2: After reset the enable is clear, every transfer goes to the external bus, and `core_rvalid`, `ext_ale`, `ext_rd` and `ext_wr` are 0.
- R3: Bit 4 of `chip_ctl` alone is the enable; it takes effect for transfers issued from the cycle after it is sampled, and the other seven bits have no effect on routing.
- R4: With the enable set, every 8-bit register-indirect transfer (`acc_ptr16`=0) is served internally, whatever the value of `acc_addr[15:8]`.
- R5: A 16-bit pointer transfer (`acc_ptr16`=1) with `acc_addr[15:8]` nonzero always goes to the external bus.
- R6: A 16-bit pointer transfer with `acc_addr[15:8]`=0 is served internally when the enable is set and externally when it is clear.
- R7: While `code_int`=1, an internally served transfer leaves `ext_addr` and `ext_wdata` unchanged and keeps `ext_ale`, `ext_rd` and `ext_wr` at 0.
- R8: While `code_int`=0, an internally served transfer keeps `ext_ale`, `ext_rd` and `ext_wr` at 0, and `ext_addr` takes the full transfer address in the next cycle.
- R9: A read strobe in cycle t gives `core_rvalid`=1 for exactly cycle t+2 with the returned byte on `core_rdata`, on both routes; an externally served read returns the `ext_rdata` value present in cycle t+1; writes give no `core_rvalid`.
- R10: An externally served transfer in cycle t drives, in cycle t+1, `ext_ale`=1, `ext_addr`=the full address, and `ext_rd`=1 for a read or `ext_wr`=1 with `ext_wdata`=the write value for a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chip_ctl | input | 8 | Chip control byte; bit 4 enables the on-chip RAM |
| code_int | input | 1 | 1 while code is fetched from internal program memory |
| acc_ptr16 | input | 1 | 1 = 16-bit pointer transfer, 0 = 8-bit register-indirect transfer |
| acc_addr | input | 16 | Transfer address |
| acc_wdata | input | 8 | Write data |
| acc_rd | input | 1 | Read strobe, one cycle |
| acc_wr | input | 1 | Write strobe, one cycle |
| core_rdata | output | 8 | Read data returned to the core |
| core_rvalid | output | 1 | Read data valid pulse |
| ext_addr | output | 16 | External bus address |
| ext_wdata | output | 8 | External bus write data |
| ext_ale | output | 1 | External address latch pulse |
| ext_rd | output | 1 | External read strobe |
| ext_wr | output | 1 | External write strobe |
| ext_rdata | input | 8 | External bus read data |

## Verification
The hardest case to reach from the ports is proving that the external bus does nothing during an internal hit. A quiet bus looks exactly like an idle one, so the bench first drives an external transfer to leave a known, distinctive value on `ext_addr` and `ext_wdata`. It then sweeps all 256 internal indices with register-indirect writes whose upper address bytes vary, and checks after each one that the held values and the silent strobes survive. Read-back through both addressing styles, with `code_int` alternating, then shows where each byte landed. High-page pointer transfers are followed by internal reads of the same low index, which shows they never reached the RAM.

// File: rtl/auxram_pkg.sv
package auxram_pkg;

  typedef enum logic {
    ACC_RI8   = 1'b0,
    ACC_PTR16 = 1'b1
  } acc_kind_e;

  // Steering rule: indirect accesses always hit when enabled; pointer
  // accesses hit only inside the low page.
  function automatic logic route_internal(acc_kind_e kind, logic hi_zero, logic en);
    return en && ((kind == ACC_RI8) || hi_zero);
  endfunction

endpackage

// File: rtl/auxram_decode.sv
module auxram_decode
  import auxram_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int AUX_AW = 8,
  parameter int CTL_W  = 8,
  parameter int EN_BIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTL_W-1:0]  chip_ctl,
  input  logic              acc_ptr16,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              en_q,
  output logic              hit
);

  localparam int HI_W = ADDR_W - AUX_AW;

  logic      hi_zero;
  acc_kind_e kind;

  always_ff @(posedge clk) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= chip_ctl[EN_BIT];
  end

  assign kind    = acc_kind_e'(acc_ptr16);
  assign hi_zero = (acc_addr[ADDR_W-1:AUX_AW] == HI_W'(0));
  assign hit     = route_internal(kind, hi_zero, en_q);

endmodule

// File: rtl/auxram_store.sv
module auxram_store #(
  parameter int DATA_W = 8,
  parameter int AUX_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [AUX_AW-1:0] idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata_q
);

  localparam int DEPTH = 1 << AUX_AW;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[idx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= mem[idx];
  end

endmodule

// File: rtl/auxram_extgate.sv
module auxram_extgate #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int AUX_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              code_int,
  input  logic              rd_go,
  input  logic              wr_go,
  input  logic              hit,
  input  logic              acc_ptr16,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [DATA_W-1:0] ext_wdata,
  output logic              ext_ale,
  output logic              ext_rd,
  output logic              ext_wr
);

  logic any_go;
  logic go_ext;
  logic hold_pins;

  assign any_go    = rd_go | wr_go;
  assign go_ext    = any_go & ~hit;
  assign hold_pins = hit & code_int;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_addr  <= '0;
      ext_wdata <= '0;
      ext_ale   <= 1'b0;
      ext_rd    <= 1'b0;
      ext_wr    <= 1'b0;
    end else begin
      ext_ale <= go_ext;
      ext_rd  <= rd_go & ~hit;
      ext_wr  <= wr_go & ~hit;
      if (any_go && !hold_pins) ext_addr  <= acc_addr;
      if (wr_go && !hold_pins)  ext_wdata <= acc_wdata;
    end
  end

  AST_INT_PINS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (any_go && hit && code_int) |=> ($stable(ext_addr) && $stable(ext_wdata))); // R7

  AST_HIT_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (any_go && hit) |=> (!ext_ale && !ext_rd && !ext_wr)); // R8

  AST_HIGH_PAGE_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (any_go && acc_ptr16 && (acc_addr[ADDR_W-1:AUX_AW] != '0)) |=> ext_ale); // R5

  AST_EXT_WRITE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && !hit) |=> (ext_wr && ext_wdata == $past(acc_wdata) && ext_addr == $past(acc_addr))); // R10

endmodule

// File: rtl/auxram_rdret.sv
module auxram_rdret #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_go,
  input  logic              rd_hit,
  input  logic [DATA_W-1:0] int_rdata,
  input  logic [DATA_W-1:0] ext_rdata,
  output logic              core_rvalid,
  output logic [DATA_W-1:0] core_rdata
);

  logic pend_rd;
  logic pend_int;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_rd     <= 1'b0;
      pend_int    <= 1'b0;
      core_rvalid <= 1'b0;
      core_rdata  <= '0;
    end else begin
      pend_rd     <= rd_go;
      pend_int    <= rd_hit;
      core_rvalid <= pend_rd;
      if (pend_rd) core_rdata <= pend_int ? int_rdata : ext_rdata;
    end
  end

  AST_READ_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    core_rvalid |-> $past(rd_go, 2)); // R9

  AST_READ_SLOT_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |=> !core_rvalid || $past(rd_go, 2)); // R9

endmodule

// File: rtl/auxram_router.sv
module auxram_router #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int AUX_AW = 8,
  parameter int CTL_W  = 8,
  parameter int EN_BIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTL_W-1:0]  chip_ctl,
  input  logic              code_int,
  input  logic              acc_ptr16,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  input  logic              acc_rd,
  input  logic              acc_wr,
  output logic [DATA_W-1:0] core_rdata,
  output logic              core_rvalid,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [DATA_W-1:0] ext_wdata,
  output logic              ext_ale,
  output logic              ext_rd,
  output logic              ext_wr,
  input  logic [DATA_W-1:0] ext_rdata
);

  logic              en_q;
  logic              hit;
  logic              rd_go;
  logic              wr_go;
  logic [DATA_W-1:0] int_rdata;

  // A cycle carrying both strobes is taken as a write.
  assign wr_go = acc_wr;
  assign rd_go = acc_rd & ~acc_wr;

  auxram_decode #(
    .ADDR_W(ADDR_W), .AUX_AW(AUX_AW), .CTL_W(CTL_W), .EN_BIT(EN_BIT)
  ) u_decode (
    .clk(clk), .rst_n(rst_n), .chip_ctl(chip_ctl), .acc_ptr16(acc_ptr16),
    .acc_addr(acc_addr), .en_q(en_q), .hit(hit)
  );

  auxram_store #(.DATA_W(DATA_W), .AUX_AW(AUX_AW)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_go & hit), .rd_en(rd_go & hit),
    .idx(acc_addr[AUX_AW-1:0]), .wdata(acc_wdata), .rdata_q(int_rdata)
  );

  auxram_extgate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .AUX_AW(AUX_AW)) u_extgate (
    .clk(clk), .rst_n(rst_n), .code_int(code_int), .rd_go(rd_go), .wr_go(wr_go),
    .hit(hit), .acc_ptr16(acc_ptr16), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_ale(ext_ale),
    .ext_rd(ext_rd), .ext_wr(ext_wr)
  );

  auxram_rdret #(.DATA_W(DATA_W)) u_rdret (
    .clk(clk), .rst_n(rst_n), .rd_go(rd_go), .rd_hit(rd_go & hit),
    .int_rdata(int_rdata), .ext_rdata(ext_rdata),
    .core_rvalid(core_rvalid), .core_rdata(core_rdata)
  );

  AST_DISABLED_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_go || wr_go) && !en_q) |=> ext_ale); // R2

  AST_RI8_INTERNAL: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_go || wr_go) && en_q && !acc_ptr16) |=> !ext_ale); // R4

endmodule

// File: tb/auxram_router_test.sv
module auxram_router_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  chip_ctl = 8'h00;
  logic        code_int = 1'b1;
  logic        acc_ptr16 = 1'b0;
  logic [15:0] acc_addr = 16'h0000;
  logic [7:0]  acc_wdata = 8'h00;
  logic        acc_rd = 1'b0;
  logic        acc_wr = 1'b0;
  logic [7:0]  core_rdata;
  logic        core_rvalid;
  logic [15:0] ext_addr;
  logic [7:0]  ext_wdata;
  logic        ext_ale, ext_rd, ext_wr;
  logic [7:0]  ext_rdata;

  int nvec = 0;
  int nbad = 0;
  bit done = 1'b0;
  bit en_model = 1'b0;
  logic [7:0] exp_mem [256];

  always #2.5 clk = ~clk;

  // External memory model: read value is a fixed function of the address.
  function automatic logic [7:0] ext_val(logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction
  assign ext_rdata = ext_val(ext_addr);

  auxram_router uut (
    .clk(clk), .rst_n(rst_n), .chip_ctl(chip_ctl), .code_int(code_int),
    .acc_ptr16(acc_ptr16), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .acc_rd(acc_rd), .acc_wr(acc_wr), .core_rdata(core_rdata),
    .core_rvalid(core_rvalid), .ext_addr(ext_addr), .ext_wdata(ext_wdata),
    .ext_ale(ext_ale), .ext_rd(ext_rd), .ext_wr(ext_wr), .ext_rdata(ext_rdata)
  );

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One transfer: drive at a falling edge, check pins one cycle later and
  // read return two cycles later.
  task automatic xfer(bit ptr16, logic [15:0] a, logic [7:0] wd, bit is_wr, string req);
    logic [15:0] pa;
    logic [7:0]  pw;
    bit          hit;
    logic [7:0]  exp_rd;
    pa  = ext_addr;
    pw  = ext_wdata;
    hit = en_model && (!ptr16 || a[15:8] == 8'h00);
    exp_rd = hit ? exp_mem[a[7:0]] : ext_val(a);
    acc_ptr16 = ptr16; acc_addr = a; acc_wdata = wd;
    acc_wr = is_wr; acc_rd = !is_wr;
    @(negedge clk);
    acc_rd = 1'b0; acc_wr = 1'b0;
    if (hit) begin
      chk({ext_ale, ext_rd, ext_wr} == 3'b000, req, {ext_ale, ext_rd, ext_wr}, 0);
      if (code_int) begin
        chk(ext_addr == pa && ext_wdata == pw, "R7", {ext_addr, ext_wdata}, {pa, pw});
      end else begin
        chk(ext_addr == a, "R8", ext_addr, a);
      end
      if (is_wr) exp_mem[a[7:0]] = wd;
    end else begin
      chk({ext_ale, ext_rd, ext_wr} == {1'b1, !is_wr, is_wr}, req,
          {ext_ale, ext_rd, ext_wr}, {1'b1, !is_wr, is_wr});
      chk(ext_addr == a, "R10", ext_addr, a);
      if (is_wr) chk(ext_wdata == wd, "R10", ext_wdata, wd);
    end
    chk(core_rvalid == 1'b0, "R9", core_rvalid, 0);
    @(negedge clk);
    if (is_wr) begin
      chk(core_rvalid == 1'b0, "R9", core_rvalid, 0);
    end else begin
      chk(core_rvalid == 1'b1, "R9", core_rvalid, 1);
      chk(core_rdata == exp_rd, hit ? "R1" : "R9", core_rdata, exp_rd);
    end
    @(negedge clk);
    chk(core_rvalid == 1'b0, "R9", core_rvalid, 0);
  endtask

  task automatic set_ctl(logic [7:0] v);
    chip_ctl = v;
    en_model = v[4];
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 reset state
    chk({core_rvalid, ext_ale, ext_rd, ext_wr} == 4'b0000, "R2",
        {core_rvalid, ext_ale, ext_rd, ext_wr}, 0);
    // R2 disabled: both styles go out
    xfer(1'b0, 16'h0012, 8'h34, 1'b1, "R2");
    xfer(1'b1, 16'h0034, 8'h00, 1'b0, "R2");
    xfer(1'b0, 16'h7712, 8'h00, 1'b0, "R2");
    // R3 every other control bit set: still external
    set_ctl(8'hEF);
    xfer(1'b0, 16'h0021, 8'h5A, 1'b1, "R3");
    xfer(1'b1, 16'h0021, 8'h00, 1'b0, "R3");
    // Leave a distinctive value on the external pins
    xfer(1'b1, 16'hBEEF, 8'hC9, 1'b1, "R10");
    // R3 enable bit alone
    set_ctl(8'h10);
    // R4 sweep: all indices, varying upper byte, code internal (R7 holds)
    code_int = 1'b1;
    for (int i = 0; i < 256; i++) begin
      xfer(1'b0, {8'(i * 7) ^ 8'hA5, 8'(i)}, 8'(i * 13 + 5), 1'b1, "R4");
    end
    // R6 low-page pointer reads, code source alternating (R7/R8)
    for (int i = 0; i < 256; i++) begin
      code_int = i[0];
      xfer(1'b1, {8'h00, 8'(i)}, 8'h00, 1'b0, "R6");
    end
    // R5 high-page pointer accesses never reach the RAM
    code_int = 1'b1;
    for (int i = 0; i < 8; i++) begin
      logic [15:0] a;
      a = {8'(8'h01 << i), 8'(i * 31)};
      xfer(1'b1, a, 8'(8'hF0 ^ i), 1'b1, "R5");
      xfer(1'b1, a, 8'h00, 1'b0, "R5");
      xfer(1'b0, {8'h00, a[7:0]}, 8'h00, 1'b0, "R5");
      xfer(1'b1, 16'hFFFF, 8'h00, 1'b0, "R5");
    end
    // R4 indirect reads with varied upper bytes, external code source
    code_int = 1'b0;
    for (int i = 0; i < 32; i++) begin
      xfer(1'b0, {8'(i * 37 + 1), 8'(i * 9)}, 8'h00, 1'b0, "R4");
    end
    xfer(1'b0, 16'h4400, 8'h77, 1'b1, "R8");
    // R6 disable again: low-page pointer goes out
    code_int = 1'b1;
    set_ctl(8'hEF);
    xfer(1'b1, 16'h0005, 8'h00, 1'b0, "R6");
    xfer(1'b0, 16'h0005, 8'h00, 1'b0, "R3");
    // R1 re-enable: stored contents still there
    set_ctl(8'h10);
    xfer(1'b1, 16'h0005, 8'h00, 1'b0, "R1");
    xfer(1'b0, 16'h1200, 8'h00, 1'b0, "R1");
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nvec++;
      nbad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

endmodule